// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, once per clock, whether the processor enters an exception handler or an interrupt handler, and produces the architectural state the core adopts on entry. A pending exception always beats an interrupt request. An interrupt is accepted only when its priority exceeds the current mask level and the core is not in the blocked state. An exception raised while blocked is turned into a reset, unless it carries the one exempt code.

On entry the block saves the status word, the program counter and the stack pointer (R15) into shadow registers. It raises the blocked, privileged and register-bank bits and records the event code. It then steers the program counter to a fixed reset address or to one of three offsets from the vector base. It also rewinds the saved PC when the faulting instruction sat in a branch delay slot, and it advances the saved PC for a trap instruction.

All results are registered. They appear one clock after the inputs that caused them, together with a one-cycle `taken_o` strobe. When nothing is taken, every output register keeps its value.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid_i` is high the exception is taken and any simultaneous interrupt request is ignored (INTEVT keeps its value).
- R2: When SR bit 28 (blocked) is set, an exception with any code other than 0x1E0 is taken as code 0x000 (reset class). Code 0x1E0 is taken unchanged.
- R3: While SR bit 28 is set, an interrupt request is not taken unless `halt_wait_i` is high.
- R4: An interrupt is taken only if `irq_prio_i` is strictly greater than the mask field SR[7:4]. Otherwise nothing is taken and no output changes.
- R5: On any entry, SSR receives the input SR, SPC the (adjusted) input PC, and SGR the input R15. The new SR is the input SR with bits 28 (blocked), 29 (bank) and 30 (privileged) set.
- R6: If either delay-slot flag (`ds_flags_i` bit 0 = unconditional slot, bit 1 = conditional slot) is set, SPC is the input PC minus 2 and `slot_clr_o` pulses with `taken_o`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15 (FPU disable), set SR[7:4] to 0xF and load PC with 0xA000_0000.
- R8: Exception codes 0x040 and 0x060 load PC with VBR+0x400. All other exception codes load PC with VBR+0x100.
- R9: For exception code 0x160, SPC is the (possibly rewound) PC plus 2.
- R10: An exception writes its effective code into EXPEVT. An interrupt writes `irq_vec_i` into INTEVT and loads PC with VBR+0x600.
- R11: Outputs update one clock after the deciding inputs. `taken_o` is high for exactly that cycle. After reset SR is 0x7000_00F0, PC is 0xA000_0000 and all other outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | External interrupt requested |
| irq_prio_i | input | 4 | Priority level of the pending interrupt |
| irq_vec_i | input | 12 | Event code of the pending interrupt |
| halt_wait_i | input | 1 | Core is halted waiting for an interrupt |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack register |
| vbr_i | input | 32 | Vector base |
| ds_flags_i | input | 2 | Delay-slot flags: bit 0 unconditional, bit 1 conditional |
| taken_o | output | 1 | One-cycle strobe: an entry was performed |
| slot_clr_o | output | 1 | Delay-slot flags must be cleared |
| sr_o | output | 32 | New status register |
| ssr_o | output | 32 | Saved status register |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt code |
| pc_o | output | 32 | New program counter |

## Verification
The assertions check on every cycle the ordering and gating rules. A pending exception is always taken. A masked or blocked interrupt never is. A blocked exception lands on the reset address with code zero. Every entry saves SR and R15 and raises the three mode bits. A cycle with no entry leaves the state untouched.

Only the bench's scenarios can show the exact vector arithmetic for each code class, and the delay-slot rewind combined with the trap advance. They also show that the exempt code survives the blocked state and that a halted core accepts an interrupt while blocked.

// File: rtl/ees_pkg.sv
package ees_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_e;

    // status register bit positions
    localparam int SR_BL_BIT  = 28;
    localparam int SR_RB_BIT  = 29;
    localparam int SR_MD_BIT  = 30;
    localparam int SR_FD_BIT  = 15;
    localparam int IMASK_LO   = 4;
    localparam int IMASK_W    = 4;

    // event codes with special handling
    localparam logic [11:0] C_PWR_RESET  = 12'h000;
    localparam logic [11:0] C_MAN_RESET  = 12'h020;
    localparam logic [11:0] C_MULTI_HIT  = 12'h140;
    localparam logic [11:0] C_MISS_RD    = 12'h040;
    localparam logic [11:0] C_MISS_WR    = 12'h060;
    localparam logic [11:0] C_TRAP       = 12'h160;
    localparam logic [11:0] C_BLK_EXEMPT = 12'h1E0;

    // entry addresses
    localparam logic [31:0] RESET_PC   = 32'hA000_0000;
    localparam logic [31:0] OFS_GEN    = 32'h0000_0100;
    localparam logic [31:0] OFS_MISS   = 32'h0000_0400;
    localparam logic [31:0] OFS_IRQ    = 32'h0000_0600;
    localparam logic [31:0] SR_RST_VAL = 32'h7000_00F0;

endpackage

// File: rtl/ees_arbiter.sv
module ees_arbiter
    import ees_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                exc_valid,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic                irq_req,
    input  logic [IMASK_W-1:0]  irq_prio,
    input  logic [CODE_W-1:0]   irq_vec,
    input  logic                halt_wait,
    input  logic                sr_bl,
    input  logic [IMASK_W-1:0]  sr_imask,
    output ev_kind_e            kind,
    output logic [CODE_W-1:0]   code
);

    logic irq_ok;

    always_comb begin
        irq_ok = irq_req && (irq_prio > sr_imask) && (!sr_bl || halt_wait);
        kind   = EV_NONE;
        code   = '0;
        if (exc_valid) begin
            kind = EV_EXC;
            if (sr_bl && (exc_code != CODE_W'(C_BLK_EXEMPT))) begin
                code = CODE_W'(C_PWR_RESET);
            end else begin
                code = exc_code;
            end
        end else if (irq_ok) begin
            kind = EV_IRQ;
            code = irq_vec;
        end
    end

endmodule

// File: rtl/ees_target.sv
module ees_target
    import ees_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  ev_kind_e            kind,
    input  logic [CODE_W-1:0]   code,
    input  logic [XLEN-1:0]     sr,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     vbr,
    input  logic [1:0]          ds_flags,
    output logic [XLEN-1:0]     sr_new,
    output logic [XLEN-1:0]     spc_new,
    output logic [XLEN-1:0]     pc_new
);

    localparam int N_RST_CODES = 3;
    localparam logic [N_RST_CODES*12-1:0] RST_LIST = {C_PWR_RESET, C_MAN_RESET, C_MULTI_HIT};

    logic [N_RST_CODES-1:0] rst_hit;
    logic is_exc, is_irq, rst_class, miss_class, is_trap, in_slot;

    for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst_match
        assign rst_hit[g] = (code == CODE_W'(RST_LIST[g*12 +: 12]));
    end

    always_comb begin
        is_exc     = (kind == EV_EXC);
        is_irq     = (kind == EV_IRQ);
        rst_class  = is_exc && (|rst_hit);
        miss_class = is_exc && ((code == CODE_W'(C_MISS_RD)) || (code == CODE_W'(C_MISS_WR)));
        is_trap    = is_exc && (code == CODE_W'(C_TRAP));
        in_slot    = |ds_flags;

        sr_new = sr;
        sr_new[SR_BL_BIT] = 1'b1;
        sr_new[SR_MD_BIT] = 1'b1;
        sr_new[SR_RB_BIT] = 1'b1;
        if (rst_class) begin
            sr_new[SR_FD_BIT] = 1'b0;
            sr_new[IMASK_LO +: IMASK_W] = '1;
        end

        spc_new = pc;
        if (in_slot) begin
            spc_new = spc_new - XLEN'(2);
        end
        if (is_trap) begin
            spc_new = spc_new + XLEN'(2);
        end

        if (is_irq) begin
            pc_new = vbr + XLEN'(OFS_IRQ);
        end else if (rst_class) begin
            pc_new = XLEN'(RESET_PC);
        end else if (miss_class) begin
            pc_new = vbr + XLEN'(OFS_MISS);
        end else begin
            pc_new = vbr + XLEN'(OFS_GEN);
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import ees_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic [3:0]        irq_prio_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic              halt_wait_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic [1:0]        ds_flags_i,
    output logic              taken_o,
    output logic              slot_clr_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   pc_o
);

    typedef struct packed {
        logic              taken;
        logic              slot_clr;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic [XLEN-1:0]   pc;
    } entry_state_t;

    ev_kind_e          kind;
    logic [CODE_W-1:0] ev_code;
    logic [XLEN-1:0]   sr_new, spc_new, pc_new;
    entry_state_t      st_d, st_q;

    ees_arbiter #(.CODE_W(CODE_W)) arb_i (
        .exc_valid (exc_valid_i),
        .exc_code  (exc_code_i),
        .irq_req   (irq_req_i),
        .irq_prio  (irq_prio_i),
        .irq_vec   (irq_vec_i),
        .halt_wait (halt_wait_i),
        .sr_bl     (sr_i[SR_BL_BIT]),
        .sr_imask  (sr_i[IMASK_LO +: IMASK_W]),
        .kind      (kind),
        .code      (ev_code)
    );

    ees_target #(.XLEN(XLEN), .CODE_W(CODE_W)) tgt_i (
        .kind     (kind),
        .code     (ev_code),
        .sr       (sr_i),
        .pc       (pc_i),
        .vbr      (vbr_i),
        .ds_flags (ds_flags_i),
        .sr_new   (sr_new),
        .spc_new  (spc_new),
        .pc_new   (pc_new)
    );

    always_comb begin
        st_d          = st_q;
        st_d.taken    = 1'b0;
        st_d.slot_clr = 1'b0;
        if (kind != EV_NONE) begin
            st_d.taken    = 1'b1;
            st_d.slot_clr = |ds_flags_i;
            st_d.sr       = sr_new;
            st_d.ssr      = sr_i;
            st_d.spc      = spc_new;
            st_d.sgr      = r15_i;
            st_d.pc       = pc_new;
            if (kind == EV_EXC) begin
                st_d.expevt = ev_code;
            end else begin
                st_d.intevt = ev_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sr     <= XLEN'(SR_RST_VAL);
            st_q.pc     <= XLEN'(RESET_PC);
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o    = st_q.taken;
    assign slot_clr_o = st_q.slot_clr;
    assign sr_o       = st_q.sr;
    assign ssr_o      = st_q.ssr;
    assign spc_o      = st_q.spc;
    assign sgr_o      = st_q.sgr;
    assign expevt_o   = st_q.expevt;
    assign intevt_o   = st_q.intevt;
    assign pc_o       = st_q.pc;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              irq_req_i,
    input logic [3:0]        irq_prio_i,
    input logic              halt_wait_i,
    input logic [XLEN-1:0]   sr_i,
    input logic [XLEN-1:0]   r15_i,
    input logic              taken_o,
    input logic              slot_clr_o,
    input logic [XLEN-1:0]   sr_o,
    input logic [XLEN-1:0]   ssr_o,
    input logic [XLEN-1:0]   sgr_o,
    input logic [CODE_W-1:0] expevt_o,
    input logic [XLEN-1:0]   pc_o
);

    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        $past(exc_valid_i) |-> taken_o); // R1

    AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        $past(exc_valid_i && !sr_i[28]) |-> expevt_o == $past(exc_code_i)); // R10

    AST_BLOCKED_RESET: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        $past(exc_valid_i && sr_i[28] && exc_code_i != CODE_W'(12'h1E0))
        |-> (expevt_o == '0 && pc_o == 32'hA000_0000)); // R2

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        $past(!exc_valid_i && irq_req_i && sr_i[28] && !halt_wait_i) |-> !taken_o); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        $past(!exc_valid_i && irq_req_i && irq_prio_i <= sr_i[7:4]) |-> !taken_o); // R4

    AST_STATE_SAVED: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        taken_o |-> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i) && sr_o[30:28] == 3'b111)); // R5

    AST_SLOT_WITH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        slot_clr_o |-> taken_o); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok_q)
        !taken_o |-> (pc_o == $past(pc_o) && sr_o == $past(sr_o) && ssr_o == $past(ssr_o)
                      && expevt_o == $past(expevt_o))); // R11

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .irq_req_i   (irq_req_i),
    .irq_prio_i  (irq_prio_i),
    .halt_wait_i (halt_wait_i),
    .sr_i        (sr_i),
    .r15_i       (r15_i),
    .taken_o     (taken_o),
    .slot_clr_o  (slot_clr_o),
    .sr_o        (sr_o),
    .ssr_o       (ssr_o),
    .sgr_o       (sgr_o),
    .expevt_o    (expevt_o),
    .pc_o        (pc_o)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    localparam logic [31:0] VBR  = 32'h8C00_0000;
    localparam logic [31:0] PC   = 32'h0000_1000;
    localparam logic [31:0] R15  = 32'h0000_2000;
    localparam logic [31:0] SR_U = 32'h0000_8030;
    localparam logic [31:0] SR_B = 32'h1000_8030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [11:0] exc_code_i = '0;
    logic        irq_req_i = 1'b0;
    logic [3:0]  irq_prio_i = '0;
    logic [11:0] irq_vec_i = '0;
    logic        halt_wait_i = 1'b0;
    logic [31:0] sr_i = '0, pc_i = '0, r15_i = '0, vbr_i = '0;
    logic [1:0]  ds_flags_i = '0;
    logic        taken_o, slot_clr_o;
    logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [11:0] expevt_o, intevt_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .irq_req_i(irq_req_i), .irq_prio_i(irq_prio_i), .irq_vec_i(irq_vec_i),
        .halt_wait_i(halt_wait_i), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i),
        .vbr_i(vbr_i), .ds_flags_i(ds_flags_i),
        .taken_o(taken_o), .slot_clr_o(slot_clr_o), .sr_o(sr_o), .ssr_o(ssr_o),
        .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
        .pc_o(pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request at the falling edge, sample after the next rising edge
    task automatic raise(input logic ev, input logic [11:0] code, input logic irq,
                         input logic [3:0] prio, input logic [11:0] vec, input logic halt,
                         input logic [31:0] sr, input logic [1:0] ds);
        @(negedge clk);
        exc_valid_i = ev;  exc_code_i = code;
        irq_req_i = irq;   irq_prio_i = prio; irq_vec_i = vec;
        halt_wait_i = halt; sr_i = sr; pc_i = PC; r15_i = R15; vbr_i = VBR;
        ds_flags_i = ds;
        @(posedge clk);
        #1;
    endtask

    task automatic drop();
        @(negedge clk);
        exc_valid_i = 1'b0; irq_req_i = 1'b0; halt_wait_i = 1'b0; ds_flags_i = '0;
        @(posedge clk);
        #1;
        chk("R11 taken pulse ends", {31'd0, taken_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset taken", {31'd0, taken_o}, 32'd0);
        chk("R11 reset sr", sr_o, 32'h7000_00F0);
        chk("R11 reset pc", pc_o, 32'hA000_0000);
        chk("R11 reset ssr", ssr_o, 32'd0);
    endtask

    task automatic t_general();
        raise(1'b1, 12'h180, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R11 general taken", {31'd0, taken_o}, 32'd1);
        chk("R5 general ssr", ssr_o, SR_U);
        chk("R5 general spc", spc_o, PC);
        chk("R5 general sgr", sgr_o, R15);
        chk("R5 general sr", sr_o, 32'h7000_8030);
        chk("R8 general pc", pc_o, VBR + 32'h100);
        chk("R10 general expevt", {20'd0, expevt_o}, 32'h180);
        chk("R6 no slot clear", {31'd0, slot_clr_o}, 32'd0);
        drop();
    endtask

    task automatic t_tlb_miss();
        raise(1'b1, 12'h040, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R8 miss read pc", pc_o, VBR + 32'h400);
        drop();
        raise(1'b1, 12'h060, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R8 miss write pc", pc_o, VBR + 32'h400);
        chk("R10 miss write expevt", {20'd0, expevt_o}, 32'h060);
        drop();
    endtask

    task automatic t_reset_class();
        raise(1'b1, 12'h140, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R7 multi-hit pc", pc_o, 32'hA000_0000);
        chk("R7 multi-hit sr", sr_o, 32'h7000_00F0);
        drop();
        raise(1'b1, 12'h020, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R7 manual reset pc", pc_o, 32'hA000_0000);
        drop();
    endtask

    task automatic t_trap();
        raise(1'b1, 12'h160, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b00);
        chk("R9 trap spc", spc_o, PC + 32'd2);
        chk("R9 trap pc", pc_o, VBR + 32'h100);
        drop();
        raise(1'b1, 12'h160, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b01);
        chk("R9 trap in slot spc", spc_o, PC);
        drop();
    endtask

    task automatic t_delay_slot();
        raise(1'b1, 12'h180, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b01);
        chk("R6 slot spc", spc_o, PC - 32'd2);
        chk("R6 slot clear", {31'd0, slot_clr_o}, 32'd1);
        drop();
        raise(1'b1, 12'h180, 1'b0, 4'd0, 12'h0, 1'b0, SR_U, 2'b10);
        chk("R6 cond slot spc", spc_o, PC - 32'd2);
        chk("R6 cond slot clear", {31'd0, slot_clr_o}, 32'd1);
        drop();
    endtask

    task automatic t_blocked_exc();
        raise(1'b1, 12'h180, 1'b0, 4'd0, 12'h0, 1'b0, SR_B, 2'b00);
        chk("R2 blocked expevt", {20'd0, expevt_o}, 32'h000);
        chk("R2 blocked pc", pc_o, 32'hA000_0000);
        chk("R2 blocked sr", sr_o, 32'h7000_00F0);
        drop();
        raise(1'b1, 12'h1E0, 1'b0, 4'd0, 12'h0, 1'b0, SR_B, 2'b00);
        chk("R2 exempt expevt", {20'd0, expevt_o}, 32'h1E0);
        chk("R2 exempt pc", pc_o, VBR + 32'h100);
        chk("R2 exempt sr", sr_o, 32'h7000_8030);
        drop();
    endtask

    task automatic t_irq();
        raise(1'b0, 12'h0, 1'b1, 4'd4, 12'h3A0, 1'b0, SR_U, 2'b00);
        chk("R4 irq above mask taken", {31'd0, taken_o}, 32'd1);
        chk("R10 irq intevt", {20'd0, intevt_o}, 32'h3A0);
        chk("R10 irq pc", pc_o, VBR + 32'h600);
        drop();
        raise(1'b0, 12'h0, 1'b1, 4'd3, 12'h3C0, 1'b0, SR_U, 2'b00);
        chk("R4 irq at mask not taken", {31'd0, taken_o}, 32'd0);
        chk("R4 irq at mask intevt", {20'd0, intevt_o}, 32'h3A0);
        chk("R11 idle pc held", pc_o, VBR + 32'h600);
        drop();
    endtask

    task automatic t_irq_blocked();
        raise(1'b0, 12'h0, 1'b1, 4'd9, 12'h520, 1'b0, SR_B, 2'b00);
        chk("R3 blocked irq not taken", {31'd0, taken_o}, 32'd0);
        chk("R3 blocked irq intevt", {20'd0, intevt_o}, 32'h3A0);
        drop();
        raise(1'b0, 12'h0, 1'b1, 4'd9, 12'h520, 1'b1, SR_B, 2'b00);
        chk("R3 halted irq taken", {31'd0, taken_o}, 32'd1);
        chk("R3 halted irq intevt", {20'd0, intevt_o}, 32'h520);
        chk("R3 halted irq pc", pc_o, VBR + 32'h600);
        drop();
    endtask

    task automatic t_priority();
        logic [11:0] int_before;
        int_before = intevt_o;
        raise(1'b1, 12'h180, 1'b1, 4'd15, 12'h600, 1'b0, SR_U, 2'b00);
        chk("R1 exception wins expevt", {20'd0, expevt_o}, 32'h180);
        chk("R1 exception wins pc", pc_o, VBR + 32'h100);
        chk("R1 intevt unchanged", {20'd0, intevt_o}, {20'd0, int_before});
        drop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_general();
        t_tlb_miss();
        t_reset_class();
        t_trap();
        t_delay_slot();
        t_blocked_exc();
        t_irq();
        t_irq_blocked();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule